// File: doc/BRIEF.md
# Per-Pin Selectable Input Debouncer

This block cleans up the raw, asynchronous level of each general-purpose input pin before it reaches edge detection. Every pin has its own stable-time window, chosen from seven decade-style settings between 1 us and 30 ms. A pin's filtered output takes a new level only after the synchronized input has held that level, with no interruption, for the selected window.

Software programs the windows through 32-bit configuration words on a plain write/read bus. Each word holds eight 4-bit per-pin fields. The top bit of a field is a write enable, so software can set one pin's window with a single write and no read-modify-write. A free-running prescaler turns the clock into a shared 1 us tick. Each pin counts these ticks while its synchronized level differs from its filtered level.

Top module: `pin_debounce`

## Requirements
- R1: Pin p is configured by bits [(p mod 8)*4+2 : (p mod 8)*4] of the word at address p/8. A write that sets bit (p mod 8)*4+3 of that word loads these three bits as the pin's code, and the new code is visible from the next cycle.
- R2: A write whose bit (p mod 8)*4+3 is clear leaves pin p's code unchanged, whatever the other three bits of that field hold.
- R3: A write that enables only one field leaves every other pin's code unchanged, even though all other bits of the word are zero. Writes to other addresses do not touch the pin.
- R4: A read of address a returns, in each 4-bit field, the pin's stored code in the low three bits and zero in the enable bit.
- R5: Codes 0 through 6 select windows of 1, 10, 100, 1000, 10000, 20000 and 30000 ticks of 1 us. Code 7 behaves exactly like code 6.
- R6: The 1 us tick fires on one cycle in every CLK_HZ/1e6 cycles. It is free-running from reset, and its first pulse comes CLK_HZ/1e6 cycles after reset is released.
- R7: While the synchronized input differs from the filtered output, the pin counts ticks. On the tick that reaches its window, the output takes the new level. A cycle in which the two agree clears the count.
- R8: Each raw input passes through two flip-flops before it reaches the filter.
- R9: After reset every code is 0. For the first three clock edges after reset, each filtered output is loaded straight from its synchronized input, with no filtering.
- R10: The pins are independent. The window and the input activity of one pin do not affect another pin's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Raw asynchronous pin levels |
| we_i | input | 1 | Configuration write strobe |
| addr_i | input | ADDR_W | Configuration word index |
| wdata_i | input | 32 | Configuration write data |
| rdata_o | output | 32 | Configuration read data for addr_i (combinational) |
| pin_o | output | NUM_PINS | Filtered pin levels |

## Verification
A single pin is held steady past its window, which shows the latency through the synchronizer and the tick count. A bounce partway through a long window is then driven; it shows whether the count restarts or only pauses. Pins with very different windows are toggled at the same time, which exposes any crosstalk or shared counting, and code 7 is held just short of and just past 30000 ticks. Sparse random toggling on all pins, checked against the reference model on every cycle, covers windows changing mid-count and toggles that land on or near a tick.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int CODE_W       = 3;
  localparam int FIELD_W      = 4;
  localparam int PINS_PER_REG = 8;
  localparam int CNT_W        = 15;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // window length in 1 us ticks; code 7 aliases the longest window
  function automatic cnt_t code_to_ticks(code_t c);
    case (c)
      3'd0:    return cnt_t'(1);
      3'd1:    return cnt_t'(10);
      3'd2:    return cnt_t'(100);
      3'd3:    return cnt_t'(1000);
      3'd4:    return cnt_t'(10000);
      3'd5:    return cnt_t'(20000);
      default: return cnt_t'(30000);
    endcase
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dbnc_timebase.sv
module dbnc_timebase #(
  parameter int DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == PRE_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  generate
    if (DIV > 1) begin : g_tick_chk
      assert_tick_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dbnc_cfg.sv
module dbnc_cfg
  import dbnc_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output code_t [NUM_PINS-1:0]  code_o
);
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int REG = p / PINS_PER_REG;
      localparam int BIT = (p % PINS_PER_REG) * FIELD_W;

      logic  hit;
      code_t code_q;

      assign hit = we_i && (addr_i == ADDR_W'(REG));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         code_q <= '0;
        else if (hit && wdata_i[BIT+CODE_W]) code_q <= wdata_i[BIT +: CODE_W];
      end

      assign code_o[p] = code_q;

      assert_field_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(REG) && wdata_i[BIT+CODE_W])
          |=> code_o[p] == $past(wdata_i[BIT +: CODE_W]));
      assert_field_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !wdata_i[BIT+CODE_W]) |=> $stable(code_o[p]));
      assert_other_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i != ADDR_W'(REG)) |=> $stable(code_o[p]));
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(p / PINS_PER_REG))
        rdata_o[(p % PINS_PER_REG) * FIELD_W +: CODE_W] = code_o[p];
    end
  end
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter
  import dbnc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ready_i,
  input  logic  tick_i,
  input  logic  sync_i,
  input  code_t code_i,
  output logic  filt_o
);
  logic filt_q;
  cnt_t cnt_q;
  cnt_t lim;

  assign lim = code_to_ticks(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!ready_i) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (sync_i == filt_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      // >= so a window shortened mid-count still terminates
      if (cnt_q >= lim - cnt_t'(1)) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + cnt_t'(1);
      end
    end
  end

  assign filt_o = filt_q;

  assert_change_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !tick_i) |=> $stable(filt_o));
  assert_hold_when_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && sync_i == filt_o) |=> $stable(filt_o));
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbnc_pkg::*;
#(
  parameter  int NUM_PINS = 16,
  parameter  int CLK_HZ   = 125_000_000,
  localparam int NUM_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG,
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] pin_o
);
  localparam int TICK_DIV = (CLK_HZ >= 2_000_000) ? CLK_HZ / 1_000_000 : 1;

  logic [NUM_PINS-1:0] sync;
  code_t [NUM_PINS-1:0] code;
  logic                tick;
  logic [1:0]          init_q;
  logic                ready;

  // outputs load directly while the synchronizer fills
  assign ready = (init_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     init_q <= '0;
    else if (!ready) init_q <= init_q + 2'd1;
  end

  dbnc_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  dbnc_timebase #(.DIV(TICK_DIV)) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dbnc_cfg #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .code_o (code)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_filt
      dbnc_filter u_filter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ready_i(ready),
        .tick_i (tick),
        .sync_i (sync[p]),
        .code_i (code[p]),
        .filt_o (pin_o[p])
      );
    end
  endgenerate

  assert_init_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> pin_o == $past(sync));
endmodule

// File: tb/pin_debounce_tb.sv
module pin_debounce_tb;
  localparam int N      = 16;
  localparam int CLK_HZ = 2_000_000; // scaled timebase keeps long windows short
  localparam int DIV    = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin = 16'hA5C3;
  logic        we = 1'b0;
  logic [0:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  pin_debounce #(.NUM_PINS(N), .CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin_o)
  );

  // behavioural reference model
  bit     m_s1[N], m_s2[N], m_filt[N];
  int     m_cnt[N], m_code[N];
  int     m_pre, m_init;
  logic [N-1:0] m_out;

  function automatic int win(int c);
    case (c)
      0: return 1;
      1: return 10;
      2: return 100;
      3: return 1000;
      4: return 10000;
      5: return 20000;
      default: return 30000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_init = 0;
      for (int p = 0; p < N; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_filt[p] = 0; m_cnt[p] = 0; m_code[p] = 0;
      end
    end else begin
      bit tk;
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      for (int p = 0; p < N; p++) begin
        if (m_init < 3) begin
          m_filt[p] = m_s2[p]; m_cnt[p] = 0;
        end else if (m_s2[p] == m_filt[p]) begin
          m_cnt[p] = 0;
        end else if (tk) begin
          if (m_cnt[p] + 1 >= win(m_code[p])) begin
            m_filt[p] = m_s2[p]; m_cnt[p] = 0;
          end else m_cnt[p] = m_cnt[p] + 1;
        end
      end
      if (we)
        for (int p = 0; p < N; p++)
          if (int'(addr) == p / 8 && wdata[(p % 8) * 4 + 3])
            m_code[p] = int'(wdata[(p % 8) * 4 +: 3]);
      for (int p = 0; p < N; p++) begin
        m_s2[p] = m_s1[p]; m_s1[p] = pin[p];
      end
      if (m_init < 3) m_init++;
    end
    for (int p = 0; p < N; p++) m_out[p] = m_filt[p];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && cmp_on) check("R7 R6 R8 R10 model", 32'(pin_o), 32'(m_out));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 1'(a); wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    addr = 1'(a);
    #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_cyc(5);
    check("R9 outputs loaded", 32'(pin_o), 32'h0000A5C3);
    rd("R9 codes zero reg0", 0, 32'h0);
    rd("R9 codes zero reg1", 1, 32'h0);

    // pin 0 at code 0: short window
    pin[0] = 1'b0;
    wait_cyc(6);
    check("R5 R7 code0 pin0", 32'(pin_o[0]), 32'h0);

    wr(0, 32'h0000_B000);                       // pin3 code 3
    rd("R1 R4 pin3 field", 0, 32'h0000_3000);
    rd("R3 reg1 untouched", 1, 32'h0);
    wr(0, 32'h0050_5000);                       // enables clear
    rd("R2 enable clear ignored", 0, 32'h0000_3000);
    wr(0, 32'h00A0_0000);                       // pin5 code 2
    rd("R3 pin3 kept", 0, 32'h0020_3000);
    wr(1, 32'h0000_0090);                       // pin9 code 1
    wr(1, 32'h7777_7777);
    rd("R2 R4 reg1", 1, 32'h0000_0010);

    // bounce on pin3 (window 1000 ticks)
    pin[3] = 1'b1;
    wait_cyc(1500);
    check("R7 pin3 before window", 32'(pin_o[3]), 32'h0);
    pin[3] = 1'b0;
    wait_cyc(10);
    pin[3] = 1'b1;
    wait_cyc(1500);
    check("R7 pin3 bounce restarts", 32'(pin_o[3]), 32'h0);
    wait_cyc(700);
    check("R7 pin3 after window", 32'(pin_o[3]), 32'h1);

    // pin9 (10 ticks) alongside pin3 toggling
    pin[9] = 1'b1;
    pin[3] = 1'b0;
    wait_cyc(10);
    check("R10 pin9 early", 32'(pin_o[9]), 32'h0);
    wait_cyc(20);
    check("R10 pin9 settled", 32'(pin_o[9]), 32'h1);
    check("R10 pin3 still high", 32'(pin_o[3]), 32'h1);

    // code 7 aliases 30000 ticks
    wr(1, 32'hF000_0000);
    rd("R4 code7 readback", 1, 32'h7000_0010);
    pin[15] = 1'b0;
    wait_cyc(59000);
    check("R5 code7 before window", 32'(pin_o[15]), 32'h1);
    wait_cyc(1200);
    check("R5 code7 after window", 32'(pin_o[15]), 32'h0);

    // sparse random activity, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 8 == 0) pin[$urandom % N] ^= 1'b1;
      if (i == 2000) begin
        we = 1'b1; addr = 1'b0; wdata = 32'h0000_0009; // pin0 code 1 mid-run
      end else begin
        we = 1'b0; wdata = '0;
      end
    end
    wait_cyc(3000);
    finish_run();
  end
endmodule